// File: doc/BRIEF.md
# Clock-Stretching Two-Wire Bus Target

This block is the target (slave) side of a two-wire serial bus controller. It watches SCL and SDA through synchronisers, detects START and STOP, shifts in a 7-bit address plus a read/write bit and compares the address with the `own_addr` input. On a match it drives the acknowledge bit, records the direction and raises a one-cycle interrupt. After that it moves whole bytes either way, one per interrupt.

Software and bus move at different speeds. The block copes by holding SCL low after every acknowledged byte. There is no ready signal at the bus edge. The clock is released only when software makes the data-register access that suits the current direction: a write while transmitting, or a read (a dummy read is enough) while receiving. The register strobes `reg_wr`/`reg_rd` are single-cycle and are never back-pressured. Every access completes in the cycle it is presented.

Register map (`reg_addr`): 0 = control, 1 = status (read-only), 2 = data. Both lines are open-drain. `scl_oe`/`sda_oe` high means the block pulls that line low.

Top module: `i2cs_top`

## Requirements
- R1: When the 7 address bits after a START equal `own_addr`, the block pulls SDA low during the ninth (acknowledge) clock. On a mismatch SDA stays released, no interrupt is raised and SCL is never held.
- R2: At the falling SCL edge that ends the acknowledge of a matched address, status bit 0 (addressed flag) goes to 1 and status bit 1 takes the received R/W bit (1 = target transmits). `irq` pulses high for exactly one clock.
- R3: Any write to the control register clears status bit 0. If that write falls in the same cycle as the address event of R2, the flag ends up set.
- R4: The interrupt event that ends a data byte clears status bit 0. A read of any register leaves the flag unchanged.
- R5: After each acknowledged byte (address or data), `scl_oe` stays high until the servicing access of R6 or R7 arrives.
- R6: With control bit 0 = 1 (transmit), a write to the data register releases SCL. The byte is then sent MSB first. Its first bit is on SDA for a few clocks before SCL is let go, and SDA does not change in the cycle SCL is released.
- R7: With control bit 0 = 0 (receive), a read of the data register releases SCL. Every received data byte is acknowledged, and it reads back from the data register from the end of its acknowledge onward.
- R8: A data-register write in receive mode, or a data-register read in transmit mode, leaves SCL held.
- R9: In transmit, the SDA level the master gives during the acknowledge clock is stored in status bit 2 (1 = no acknowledge). After a no-acknowledge the byte's interrupt still pulses, but SDA is released and SCL is not held again.
- R10: A STOP or a START detected in any state returns the block to address detection. In the following cycle both `scl_oe` and `sda_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address the block answers to |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge or data 0) |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on `reg_addr` |
| irq | output | 1 | One-cycle pulse at the end of each address or data byte |

## Verification
Two writers of the addressed flag can meet in one clock. One is a control-register write that clears it. The other is the end of a matched address acknowledge, which sets it. The bench provokes the collision by holding the control write strobe high, one write per cycle, from before the address byte until it sees `irq`, so the last write lands on the edge where the address event is registered. The flag must read 1 afterwards, and one further control write must clear it.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int BCNT_W = $clog2(BYTE_W + 1);

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_HOLD, S_SETUP, S_TX, S_TACK, S_RX, S_RACK
  } tgt_state_t;
endpackage

// File: rtl/i2cs_linesync.sv
module i2cs_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q[0] <= scl_i;
      sda_q[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_q[i] <= scl_q[i-1];
        sda_q[i] <= sda_q[i-1];
      end
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_now   = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = !scl_p && scl_now;
  assign scl_fall  = scl_p && !scl_now;
  // SDA moving while SCL stayed high across both samples
  assign start_det = scl_p && scl_now && sda_p && !sda_s;
  assign stop_det  = scl_p && scl_now && !sda_p && sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int SETUP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rel_tx,
  input  logic              rel_rx,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              ev_addr,
  output logic              ev_rw,
  output logic              ev_data,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ack_evt,
  output logic              ack_val,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int SCW = $clog2(SETUP_CYC + 1);
  localparam logic [SCW-1:0]    SC_LAST = SCW'(SETUP_CYC - 1);
  localparam logic [BCNT_W-1:0] B_FULL  = BCNT_W'(BYTE_W);
  localparam logic [BCNT_W-1:0] B_LAST  = BCNT_W'(BYTE_W - 1);

  tgt_state_t        st;
  logic [BYTE_W-1:0] sh;
  logic [BCNT_W-1:0] bcnt;
  logic [SCW-1:0]    scnt;
  logic              rw_q, nack_q;

  assign ev_addr = (st == S_AACK) && scl_fall;
  assign ev_rw   = rw_q;
  assign ev_data = ((st == S_RACK) || (st == S_TACK)) && scl_fall;
  assign rx_load = (st == S_RACK) && scl_fall;
  assign rx_byte = sh;
  assign ack_evt = (st == S_TACK) && scl_rise;
  assign ack_val = sda_s;
  assign scl_oe  = (st == S_HOLD) || (st == S_SETUP);
  assign sda_oe  = (st == S_AACK) || (st == S_RACK) ||
                   (((st == S_SETUP) || (st == S_TX)) && !sh[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      bcnt   <= '0;
      scnt   <= '0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
    end else if (start_det) begin
      st   <= S_ADDR;
      bcnt <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: ;
        S_ADDR, S_RX: begin
          if (scl_rise && bcnt != B_FULL) begin
            sh   <= {sh[BYTE_W-2:0], sda_s};
            bcnt <= bcnt + BCNT_W'(1);
          end else if (scl_fall && bcnt == B_FULL) begin
            if (st == S_RX) begin
              st <= S_RACK;
            end else if (sh[BYTE_W-1:1] == own_addr) begin
              st   <= S_AACK;
              rw_q <= sh[0];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK, S_RACK: if (scl_fall) st <= S_HOLD;
        S_HOLD: begin
          if (rel_tx) begin
            sh   <= tx_byte;
            scnt <= '0;
            st   <= S_SETUP;
          end else if (rel_rx) begin
            bcnt <= '0;
            st   <= S_RX;
          end
        end
        S_SETUP: begin
          if (scnt == SC_LAST) begin
            bcnt <= '0;
            st   <= S_TX;
          end else begin
            scnt <= scnt + SCW'(1);
          end
        end
        S_TX: begin
          if (scl_fall) begin
            sh <= {sh[BYTE_W-2:0], 1'b0};
            if (bcnt == B_LAST) st <= S_TACK;
            else bcnt <= bcnt + BCNT_W'(1);
          end
        end
        S_TACK: begin
          if (scl_rise) nack_q <= sda_s;
          if (scl_fall) st <= nack_q ? S_IDLE : S_HOLD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              ev_addr,
  input  logic              ev_rw,
  input  logic              ev_data,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ack_evt,
  input  logic              ack_val,
  output logic              rel_tx,
  output logic              rel_rx,
  output logic              aas_o,
  output logic              irq
);
  logic              tx_sel, aas, srw, rxak;
  logic [BYTE_W-1:0] rx_data;
  logic              ctrl_wr;

  assign ctrl_wr = reg_wr && reg_addr == REG_CTRL;
  assign rel_tx  = reg_wr && reg_addr == REG_DATA && tx_sel;
  assign rel_rx  = reg_rd && reg_addr == REG_DATA && !tx_sel;
  assign aas_o   = aas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sel  <= 1'b0;
      aas     <= 1'b0;
      srw     <= 1'b0;
      rxak    <= 1'b0;
      rx_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= ev_addr || ev_data;
      if (ctrl_wr) tx_sel <= reg_wdata[0];
      // a fresh address event outranks a clearing control write
      if (ev_addr) aas <= 1'b1;
      else if (ctrl_wr || ev_data) aas <= 1'b0;
      if (ev_addr) srw <= ev_rw;
      if (ack_evt) rxak <= ack_val;
      if (rx_load) rx_data <= rx_byte;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {{(BYTE_W-1){1'b0}}, tx_sel};
      REG_STAT: reg_rdata = {{(BYTE_W-3){1'b0}}, rxak, srw, aas};
      REG_DATA: reg_rdata = rx_data;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  own_addr,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ev_addr, ev_rw, ev_data, rx_load, ack_evt, ack_val;
  logic rel_tx, rel_rx, aas_q;
  logic [BYTE_W-1:0] rx_byte;

  i2cs_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.SETUP_CYC(SETUP_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rel_tx(rel_tx), .rel_rx(rel_rx), .tx_byte(reg_wdata),
    .ev_addr(ev_addr), .ev_rw(ev_rw), .ev_data(ev_data),
    .rx_load(rx_load), .rx_byte(rx_byte),
    .ack_evt(ack_evt), .ack_val(ack_val),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2cs_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_addr(ev_addr), .ev_rw(ev_rw), .ev_data(ev_data),
    .rx_load(rx_load), .rx_byte(rx_byte),
    .ack_evt(ack_evt), .ack_val(ack_val),
    .rel_tx(rel_tx), .rel_rx(rel_rx), .aas_o(aas_q), .irq(irq)
  );
endmodule

// File: rtl/i2cs_checks.sv
module i2cs_checks
  import i2cs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       bus_evt,
  input logic       aas,
  input logic       ev_addr
);
  a_r3_ctrl_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_CTRL && !ev_addr) |=> !aas);

  a_r2_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aas) |-> irq);

  a_r2_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r10_bus_event_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> (!scl_oe && !sda_oe));

  a_r6_sda_settled_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $stable(sda_oe));
endmodule

bind i2cs_top i2cs_checks u_checks (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .bus_evt(start_det || stop_det),
  .aas(aas_q), .ev_addr(ev_addr)
);

// File: tb/i2cs_top_bench.sv
`timescale 1ns/1ps
module i2cs_top_bench;
  localparam int HP = 20;
  localparam logic [6:0] OWN = 7'h52;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_bus, sda_bus;
  int checks = 0, errors = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;
  assign scl_bus = !(scl_oe || m_scl_low);
  assign sda_bus = !(sda_oe || m_sda_low);

  i2cs_top u_i2cs_top (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // bus master model
  task automatic m_bit(input logic drive_low, output logic s);
    m_sda_low = drive_low;
    settle(HP / 2);
    m_scl_low = 1'b0;
    while (!scl_bus) @(negedge clk);
    settle(HP / 2);
    s = sda_bus;
    settle(HP / 2);
    m_scl_low = 1'b1;
    settle(HP / 2);
  endtask

  task automatic m_start;
    m_sda_low = 1'b0; m_scl_low = 1'b0; settle(HP);
    m_sda_low = 1'b1; settle(HP);
    m_scl_low = 1'b1;
  endtask

  task automatic m_rstart;
    m_sda_low = 1'b0; settle(HP);
    m_scl_low = 1'b0;
    while (!scl_bus) @(negedge clk);
    settle(HP);
    m_sda_low = 1'b1; settle(HP);
    m_scl_low = 1'b1;
  endtask

  task automatic m_stop;
    m_sda_low = 1'b1; settle(HP);
    m_scl_low = 1'b0;
    while (!scl_bus) @(negedge clk);
    settle(HP);
    m_sda_low = 1'b0; settle(HP);
  endtask

  task automatic m_write(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(!b[i], s);
    m_bit(1'b0, s);
    ack = !s;
  endtask

  task automatic m_read(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b0, s);
      b[i] = s;
    end
    m_bit(!nack, s);
  endtask

  // scenarios
  task automatic t_reset;
    logic [7:0] d;
    chk("R10 reset scl_oe", scl_oe, 0);
    chk("R10 reset sda_oe", sda_oe, 0);
    reg_read(2'd1, d);
    chk("R2 reset status", d, 0);
  endtask

  task automatic t_mismatch;
    logic ack; int base;
    base = irq_cnt;
    m_start;
    m_write({OWN ^ 7'h01, 1'b0}, ack);
    chk("R1 no ack on other address", ack, 0);
    chk("R1 no irq on other address", irq_cnt - base, 0);
    chk("R1 no stretch on other address", scl_oe, 0);
    m_stop;
  endtask

  task automatic t_write_flow;
    logic ack; logic [7:0] d; int base;
    base = irq_cnt;
    m_start;
    m_write({OWN, 1'b0}, ack);
    chk("R1 ack on own address", ack, 1);
    chk("R2 one irq after address", irq_cnt - base, 1);
    reg_read(2'd1, d);
    chk("R2 status aas=1 srw=0", d[1:0], 2'b01);
    chk("R5 stretch after address", scl_oe, 1);
    reg_write(2'd2, 8'h77);
    settle(6);
    chk("R8 data write in receive keeps SCL held", scl_oe, 1);
    reg_read(2'd1, d);
    chk("R4 reads leave aas set", d[0], 1);
    reg_read(2'd2, d);
    chk("R7 dummy read releases SCL", scl_oe, 0);
    m_write(8'hA5, ack);
    chk("R7 data byte acknowledged", ack, 1);
    chk("R5 stretch after data byte", scl_oe, 1);
    reg_read(2'd1, d);
    chk("R4 data irq clears aas", d[0], 0);
    reg_read(2'd2, d);
    chk("R7 received byte A5", d, 8'hA5);
    m_write(8'h5A, ack);
    reg_read(2'd2, d);
    chk("R7 received byte 5A", d, 8'h5A);
    chk("R2 irq count over write flow", irq_cnt - base, 3);
    m_stop;
    settle(4);
    chk("R10 STOP releases lines", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_read_flow;
    logic ack; logic [7:0] d; int base;
    m_start;
    m_write({OWN, 1'b1}, ack);
    reg_read(2'd1, d);
    chk("R2 status aas=1 srw=1", d[1:0], 2'b11);
    reg_write(2'd0, 8'h01);
    reg_read(2'd1, d);
    chk("R3 control write clears aas", d[1:0], 2'b10);
    reg_read(2'd2, d);
    settle(6);
    chk("R8 data read in transmit keeps SCL held", scl_oe, 1);
    reg_write(2'd2, 8'h3C);
    m_read(1'b0, d);
    chk("R6 master reads 3C", d, 8'h3C);
    reg_read(2'd1, d);
    chk("R9 ack stored as 0", d[2], 0);
    chk("R5 stretch after acked transmit byte", scl_oe, 1);
    base = irq_cnt;
    reg_write(2'd2, 8'hC3);
    m_read(1'b1, d);
    chk("R6 master reads C3", d, 8'hC3);
    chk("R9 irq after nacked byte", irq_cnt - base, 1);
    reg_read(2'd1, d);
    chk("R9 no-ack stored as 1", d[2], 1);
    settle(10);
    chk("R9 no stretch after no-ack", {scl_oe, sda_oe}, 2'b00);
    m_rstart;
    m_write({OWN, 1'b0}, ack);
    chk("R10 repeated START restarts address match", ack, 1);
    reg_read(2'd1, d);
    chk("R10 aas=1 srw=0 after repeated START", d[1:0], 2'b01);
    reg_write(2'd0, 8'h00);
    reg_read(2'd2, d);
    m_stop;
    settle(4);
    chk("R10 STOP after receive releases lines", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_collision;
    logic ack; logic [7:0] d;
    fork
      begin
        m_start;
        m_write({OWN, 1'b0}, ack);
      end
      begin
        @(negedge clk); reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1;
        @(negedge clk);
        while (!irq) @(negedge clk);
        reg_wr = 1'b0;
      end
    join
    reg_read(2'd1, d);
    chk("R3 set wins over same-cycle control write", d[0], 1);
    reg_write(2'd0, 8'h00);
    reg_read(2'd1, d);
    chk("R3 later control write clears aas", d[0], 0);
    reg_read(2'd2, d);
    m_stop;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    settle(5);
    rst_n = 1'b1;
    settle(5);
    t_reset;
    t_mismatch;
    t_write_flow;
    t_read_flow;
    t_collision;
    settle(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule